// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block runs the stack side of an interrupt or exception entry once the gate has already been fetched. It takes the gate's target selector, 32-bit offset and type, the mode and privilege state of the processor, and the current register values. It then issues a series of stack-push requests over a valid/ready port. At the end it reports the new stack segment, stack pointer, flags, code segment and instruction pointer. A pulse marks success; a separate pulse marks an abort.

In protected mode, if the current privilege level is numerically above the requested privilege level of the target selector, the machine moves to the inner ring's stack. It takes that stack from a per-ring table that covers rings 0 to 2 and saves the old stack location on the new stack. The push width comes from the gate's size. In real mode every gate is handled as a 16-bit interrupt gate, the stack never switches, and pushes are always 16 bits wide.

Each segment selector the machine loads (the inner stack segment and the new code segment) is offered on a check port and must be accepted there. A rejected check or a push that returns an error ends the entry at once. The committed outputs then keep their earlier values, so the operand-size state of the caller is left untouched.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, busy, push_valid, seg_chk_valid, done and abort are low and all out_* registers are zero.
- R2: Without a stack switch the machine pushes exactly three items in this order: flags, current CS selector (zero-extended), current instruction pointer.
- R3: In protected mode with cpl greater than gate_sel[1:0], the machine first offers ring_ss slice [gate_sel[1:0]] on the check port. It then loads SS and the stack pointer from that ring's slices and pushes the old SS (zero-extended) and the old stack pointer ahead of the R2 frame. All pushes of an entry go to the stack segment that is in use after any switch.
- R4: A push is 32 bits wide (push_wide=1, stack pointer minus 4) only in protected mode with gate_type 4'hE or 4'hF. In every other case it is 16 bits wide: push_wide=0, only the low 16 data bits are driven, the upper bits are zero, and the stack pointer drops by 2. push_addr carries the already-decremented pointer. The width does not depend on cs_wide.
- R5: Flags bit 9 is cleared in out_flags for gate types 4'h6 and 4'hE and for every real-mode entry. For other types in protected mode the flags are passed through unchanged.
- R6: After all pushes, gate_sel is offered on the check port and, on success, becomes out_cs. out_ip is the full gate_off for a 32-bit gate; otherwise it is cur_ip with its low 16 bits replaced by gate_off[15:0].
- R7: In real mode gate_type and cpl are ignored. There is no stack switch, pushes are 16 bits wide, and the flags bit 9 is cleared.
- R8: A push accepted with push_err high, or a check answered with seg_chk_ok low, gives a one-cycle abort pulse. No further push follows it, done stays low, and every out_* register keeps its previous value.
- R9: Success gives a one-cycle done pulse with busy low. A start while busy is ignored, and inputs are captured only at an accepted start.
- R10: While push_valid is high and push_ready low, push_valid, push_data, push_addr, push_wide and push_seg hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an entry (accepted when idle) |
| prot_en | input | 1 | Protected mode enabled |
| cpl | input | PLW | Current privilege level |
| cs_wide | input | 1 | Current code segment is 32-bit |
| gate_sel | input | SELW | Gate target selector |
| gate_off | input | AW | Gate target offset |
| gate_type | input | 4 | Gate type code |
| cur_ss | input | SELW | Current stack selector |
| cur_sp | input | AW | Current stack pointer |
| cur_flags | input | AW | Current flags word |
| cur_cs | input | SELW | Current code selector |
| cur_ip | input | AW | Current instruction pointer |
| ring_ss | input | RINGS*SELW | Per-ring stack selectors, ring r in slice r |
| ring_sp | input | RINGS*AW | Per-ring stack pointers, ring r in slice r |
| busy | output | 1 | Entry in progress |
| push_valid | output | 1 | Push request valid |
| push_ready | input | 1 | Push request accepted this cycle |
| push_err | input | 1 | Accepted push failed |
| push_wide | output | 1 | Push is 32 bits |
| push_seg | output | SELW | Stack selector for the push |
| push_addr | output | AW | Decremented stack pointer for the push |
| push_data | output | AW | Push data |
| seg_chk_valid | output | 1 | Selector load check requested |
| seg_chk_sel | output | SELW | Selector being loaded |
| seg_chk_ok | input | 1 | Selector load accepted |
| done | output | 1 | Entry completed pulse |
| abort | output | 1 | Entry aborted pulse |
| out_ss | output | SELW | Committed stack selector |
| out_sp | output | AW | Committed stack pointer |
| out_flags | output | AW | Committed flags |
| out_cs | output | SELW | Committed code selector |
| out_ip | output | AW | Committed instruction pointer |

## Verification
Entries are driven in both modes, for all four gate types, with cpl and target privilege chosen at random, so that switch and no-switch frames and 16-bit and 32-bit widths are each produced with both values of cs_wide. This exposes any width decision that wrongly depends on the code segment size, and any switch taken in real mode. Directed runs inject a push error at a chosen slot and reject either the first or the last selector check. These runs separate the abort paths from one another and confirm that the committed outputs are kept. Random push stalls and stray start pulses carrying scrambled inputs show whether request holding and input capture are correct.

// File: rtl/ies_pkg.sv
// Shared types and constants for the interrupt entry stack sequencer.
// Assumes the gate type code values used by the descriptor decoder.
package ies_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_PUSH,
        ST_LOADCS
    } ies_state_t;

    localparam logic [3:0] GT_INT16  = 4'h6;
    localparam logic [3:0] GT_TRAP16 = 4'h7;
    localparam logic [3:0] GT_INT32  = 4'hE;
    localparam logic [3:0] GT_TRAP32 = 4'hF;

    localparam int SLOTW = 3;
    localparam logic [SLOTW-1:0] SLOT_SS    = 3'd0;
    localparam logic [SLOTW-1:0] SLOT_SP    = 3'd1;
    localparam logic [SLOTW-1:0] SLOT_FLAGS = 3'd2;
    localparam logic [SLOTW-1:0] SLOT_CS    = 3'd3;
    localparam logic [SLOTW-1:0] SLOT_IP    = 3'd4;

    localparam int IF_BIT = 9;
    localparam int HALF_W = 16;
endpackage

// File: rtl/ies_gate_dec.sv
// Gate decoder: derives push width, interrupt-flag masking and the stack
// switch decision from mode, privilege and gate type. Purely combinational.
// Assumes the target privilege is the low bits of the gate selector.
module ies_gate_dec
    import ies_pkg::*;
#(
    parameter int PLW = 2
) (
    input  logic           prot,
    input  logic           cs_wide,
    input  logic [3:0]     gtype,
    input  logic [PLW-1:0] cpl,
    input  logic [PLW-1:0] rpl,
    output logic           wide,
    output logic           mask_if,
    output logic           switch_stk
);
    logic gate32;
    logic toggle;

    // Gate size from its type code.
    always_comb gate32 = (gtype == GT_INT32) || (gtype == GT_TRAP32);

    // Operand size: start from CS size, flip when the gate size differs; real mode forces 16.
    always_comb begin
        toggle = prot && (gate32 != cs_wide);
        wide   = prot ? (cs_wide ^ toggle) : 1'b0;
    end

    // Flag masking and stack switch decision.
    always_comb begin
        if (prot) begin
            mask_if    = (gtype == GT_INT16) || (gtype == GT_INT32);
            switch_stk = cpl > rpl;
        end else begin
            mask_if    = 1'b1;
            switch_stk = 1'b0;
        end
    end
endmodule

// File: rtl/ies_ring_sel.sv
// Per-ring stack selector: picks the inner-ring stack selector and pointer
// for the target privilege level out of flat packed tables.
// Assumes ring r lives in slice r; an out-of-table ring yields zeros.
module ies_ring_sel #(
    parameter int RINGS = 3,
    parameter int PLW   = 2,
    parameter int SELW  = 16,
    parameter int AW    = 32
) (
    input  logic [RINGS*SELW-1:0] ring_ss,
    input  logic [RINGS*AW-1:0]   ring_sp,
    input  logic [PLW-1:0]        rpl,
    output logic [SELW-1:0]       sel_ss,
    output logic [AW-1:0]         sel_sp
);
    logic [SELW-1:0] ss_tab [RINGS];
    logic [AW-1:0]   sp_tab [RINGS];

    genvar g;
    generate
        for (g = 0; g < RINGS; g++) begin : g_unpack
            assign ss_tab[g] = ring_ss[g*SELW +: SELW];
            assign sp_tab[g] = ring_sp[g*AW +: AW];
        end
    endgenerate

    // Multiplex the entry that matches the target ring.
    always_comb begin
        sel_ss = '0;
        sel_sp = '0;
        for (int r = 0; r < RINGS; r++) begin
            if (rpl == PLW'(r)) begin
                sel_ss = ss_tab[r];
                sel_sp = sp_tab[r];
            end
        end
    end
endmodule

// File: rtl/ies_frame_mux.sv
// Frame multiplexer: chooses the value for the current push slot, trims it
// to 16 bits for narrow pushes, and computes the decremented stack pointer.
// Assumes slots are numbered as in the package.
module ies_frame_mux
    import ies_pkg::*;
#(
    parameter int SELW = 16,
    parameter int AW   = 32
) (
    input  logic [SLOTW-1:0] slot,
    input  logic             wide,
    input  logic [SELW-1:0]  old_ss,
    input  logic [AW-1:0]    old_sp,
    input  logic [AW-1:0]    flags,
    input  logic [SELW-1:0]  cs,
    input  logic [AW-1:0]    ip,
    input  logic [AW-1:0]    sp,
    output logic [AW-1:0]    data,
    output logic [AW-1:0]    next_sp
);
    localparam logic [AW-1:0] STEP_W = AW'(4);
    localparam logic [AW-1:0] STEP_N = AW'(2);

    logic [AW-1:0] raw;

    // Select the slot value.
    always_comb begin
        unique case (slot)
            SLOT_SS:    raw = {{(AW-SELW){1'b0}}, old_ss};
            SLOT_SP:    raw = old_sp;
            SLOT_FLAGS: raw = flags;
            SLOT_CS:    raw = {{(AW-SELW){1'b0}}, cs};
            default:    raw = ip;
        endcase
    end

    // Trim narrow pushes and step the pointer.
    always_comb begin
        data    = wide ? raw : {{(AW-HALF_W){1'b0}}, raw[HALF_W-1:0]};
        next_sp = sp - (wide ? STEP_W : STEP_N);
    end
endmodule

// File: rtl/int_entry_seq.sv
// Interrupt entry stack sequencer. Captures the entry inputs on start,
// optionally switches to an inner-ring stack, pushes the frame over a
// valid/ready port, checks the new CS, and commits the new state on done.
// Assumes selector validation and memory writes are done by neighbours
// answering seg_chk_ok and push_ready/push_err in the same cycle.
module int_entry_seq
    import ies_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SELW  = 16,
    parameter int PLW   = 2,
    parameter int RINGS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  prot_en,
    input  logic [PLW-1:0]        cpl,
    input  logic                  cs_wide,
    input  logic [SELW-1:0]       gate_sel,
    input  logic [AW-1:0]         gate_off,
    input  logic [3:0]            gate_type,
    input  logic [SELW-1:0]       cur_ss,
    input  logic [AW-1:0]         cur_sp,
    input  logic [AW-1:0]         cur_flags,
    input  logic [SELW-1:0]       cur_cs,
    input  logic [AW-1:0]         cur_ip,
    input  logic [RINGS*SELW-1:0] ring_ss,
    input  logic [RINGS*AW-1:0]   ring_sp,
    output logic                  busy,
    output logic                  push_valid,
    input  logic                  push_ready,
    input  logic                  push_err,
    output logic                  push_wide,
    output logic [SELW-1:0]       push_seg,
    output logic [AW-1:0]         push_addr,
    output logic [AW-1:0]         push_data,
    output logic                  seg_chk_valid,
    output logic [SELW-1:0]       seg_chk_sel,
    input  logic                  seg_chk_ok,
    output logic                  done,
    output logic                  abort,
    output logic [SELW-1:0]       out_ss,
    output logic [AW-1:0]         out_sp,
    output logic [AW-1:0]         out_flags,
    output logic [SELW-1:0]       out_cs,
    output logic [AW-1:0]         out_ip
);
    localparam logic [AW-1:0] IF_MASK = AW'(1) << IF_BIT;

    ies_state_t      state;
    logic [SLOTW-1:0] slot;

    // Latched entry context.
    logic            l_wide, l_mask;
    logic [SELW-1:0] l_sel, l_new_ss, l_old_ss, l_cs;
    logic [AW-1:0]   l_off, l_new_sp, l_old_sp, l_flags, l_ip;

    // Working stack.
    logic [SELW-1:0] w_ss;
    logic [AW-1:0]   w_sp;

    // Decoder results.
    logic            d_wide, d_mask, d_switch;
    logic [SELW-1:0] r_ss;
    logic [AW-1:0]   r_sp;
    logic [AW-1:0]   fm_data, fm_next_sp;

    logic            done_q, abort_q;
    logic            take_start, sw_ok, push_ok, cs_ok, fail;

    ies_gate_dec #(.PLW(PLW)) u_dec (
        .prot       (prot_en),
        .cs_wide    (cs_wide),
        .gtype      (gate_type),
        .cpl        (cpl),
        .rpl        (gate_sel[PLW-1:0]),
        .wide       (d_wide),
        .mask_if    (d_mask),
        .switch_stk (d_switch)
    );

    ies_ring_sel #(.RINGS(RINGS), .PLW(PLW), .SELW(SELW), .AW(AW)) u_ring (
        .ring_ss (ring_ss),
        .ring_sp (ring_sp),
        .rpl     (gate_sel[PLW-1:0]),
        .sel_ss  (r_ss),
        .sel_sp  (r_sp)
    );

    ies_frame_mux #(.SELW(SELW), .AW(AW)) u_mux (
        .slot    (slot),
        .wide    (l_wide),
        .old_ss  (l_old_ss),
        .old_sp  (l_old_sp),
        .flags   (l_flags),
        .cs      (l_cs),
        .ip      (l_ip),
        .sp      (w_sp),
        .data    (fm_data),
        .next_sp (fm_next_sp)
    );

    // Step qualifiers for the sequencer.
    always_comb begin
        take_start = (state == ST_IDLE) && start;
        sw_ok      = (state == ST_SWITCH) && seg_chk_ok;
        push_ok    = (state == ST_PUSH) && push_ready && !push_err;
        cs_ok      = (state == ST_LOADCS) && seg_chk_ok;
        fail       = ((state == ST_SWITCH) && !seg_chk_ok)
                   || ((state == ST_PUSH) && push_ready && push_err)
                   || ((state == ST_LOADCS) && !seg_chk_ok);
    end

    // Port drive from current state.
    always_comb begin
        busy          = state != ST_IDLE;
        push_valid    = state == ST_PUSH;
        push_wide     = l_wide;
        push_seg      = w_ss;
        push_addr     = fm_next_sp;
        push_data     = fm_data;
        seg_chk_valid = (state == ST_SWITCH) || (state == ST_LOADCS);
        seg_chk_sel   = (state == ST_SWITCH) ? l_new_ss : l_sel;
        done          = done_q;
        abort         = abort_q;
    end

    // State and slot sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            if (take_start) begin
                state <= d_switch ? ST_SWITCH : ST_PUSH;
                slot  <= d_switch ? SLOT_SS : SLOT_FLAGS;
            end else if (fail || cs_ok) begin
                state <= ST_IDLE;
            end else if (sw_ok) begin
                state <= ST_PUSH;
            end else if (push_ok) begin
                if (slot == SLOT_IP) state <= ST_LOADCS;
                else                 slot  <= slot + 1'b1;
            end
        end
    end

    // Capture of the entry context at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_wide   <= 1'b0;
            l_mask   <= 1'b0;
            l_sel    <= '0;
            l_new_ss <= '0;
            l_old_ss <= '0;
            l_cs     <= '0;
            l_off    <= '0;
            l_new_sp <= '0;
            l_old_sp <= '0;
            l_flags  <= '0;
            l_ip     <= '0;
        end else if (take_start) begin
            l_wide   <= d_wide;
            l_mask   <= d_mask;
            l_sel    <= gate_sel;
            l_new_ss <= r_ss;
            l_old_ss <= cur_ss;
            l_cs     <= cur_cs;
            l_off    <= gate_off;
            l_new_sp <= r_sp;
            l_old_sp <= cur_sp;
            l_flags  <= cur_flags;
            l_ip     <= cur_ip;
        end
    end

    // Working stack segment and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_ss <= '0;
            w_sp <= '0;
        end else if (take_start) begin
            w_ss <= cur_ss;
            w_sp <= cur_sp;
        end else if (sw_ok) begin
            w_ss <= l_new_ss;
            w_sp <= l_new_sp;
        end else if (push_ok) begin
            w_sp <= fm_next_sp;
        end
    end

    // Commit of results and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ss    <= '0;
            out_sp    <= '0;
            out_flags <= '0;
            out_cs    <= '0;
            out_ip    <= '0;
            done_q    <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            done_q  <= cs_ok;
            abort_q <= fail;
            if (cs_ok) begin
                out_ss    <= w_ss;
                out_sp    <= w_sp;
                out_flags <= l_mask ? (l_flags & ~IF_MASK) : l_flags;
                out_cs    <= l_sel;
                out_ip    <= l_wide ? l_off : {l_ip[AW-1:HALF_W], l_off[HALF_W-1:0]};
            end
        end
    end

    // R10: a stalled push request holds its contents.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data)
            && $stable(push_addr) && $stable(push_seg) && $stable(push_wide)));

    // R4: an accepted push moves the stack pointer to the address it wrote.
    p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !push_err) |=> (w_sp == $past(push_addr)));

    // R8: done and abort never coincide; abort keeps committed state.
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort));
    p_abort_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ($stable(out_cs) && $stable(out_ip) && $stable(out_sp)));

    // R9: completion is seen with the machine idle; pushes only while busy.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || abort) |-> !busy);
    p_push_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> busy);

    // R5: an interrupt-gate entry never commits with the flag set.
    p_if_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_mask) |-> !out_flags[IF_BIT]);
endmodule

// File: tb/tb_int_entry_seq.sv
`timescale 1ns/1ps
module tb_int_entry_seq;
    localparam int AW = 32, SELW = 16, PLW = 2, RINGS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start = 0, prot_en = 0, cs_wide = 0;
    logic [PLW-1:0] cpl = 0;
    logic [SELW-1:0] gate_sel = 0, cur_ss = 0, cur_cs = 0;
    logic [AW-1:0] gate_off = 0, cur_sp = 0, cur_flags = 0, cur_ip = 0;
    logic [3:0] gate_type = 0;
    logic [RINGS*SELW-1:0] ring_ss = 0;
    logic [RINGS*AW-1:0] ring_sp = 0;
    logic push_ready = 0, push_err = 0, seg_chk_ok = 1;

    logic busy, push_valid, push_wide, seg_chk_valid, done, abort;
    logic [SELW-1:0] push_seg, seg_chk_sel, out_ss, out_cs;
    logic [AW-1:0] push_addr, push_data, out_sp, out_flags, out_ip;

    int_entry_seq #(.AW(AW), .SELW(SELW), .PLW(PLW), .RINGS(RINGS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_en(prot_en), .cpl(cpl),
        .cs_wide(cs_wide), .gate_sel(gate_sel), .gate_off(gate_off),
        .gate_type(gate_type), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .ring_ss(ring_ss), .ring_sp(ring_sp), .busy(busy),
        .push_valid(push_valid), .push_ready(push_ready), .push_err(push_err),
        .push_wide(push_wide), .push_seg(push_seg), .push_addr(push_addr),
        .push_data(push_data), .seg_chk_valid(seg_chk_valid),
        .seg_chk_sel(seg_chk_sel), .seg_chk_ok(seg_chk_ok), .done(done),
        .abort(abort), .out_ss(out_ss), .out_sp(out_sp), .out_flags(out_flags),
        .out_cs(out_cs), .out_ip(out_ip)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;

    // Expected entry.
    int e_n, e_nchk;
    bit e_sw, e_wide;
    logic [AW-1:0] e_data [5];
    logic [AW-1:0] e_addr [5];
    logic [SELW-1:0] e_seg, e_ss, e_cs, e_ringss;
    logic [AW-1:0] e_sp, e_flags, e_ip;
    // Last committed values.
    logic [SELW-1:0] p_ss = 0, p_cs = 0;
    logic [AW-1:0] p_sp = 0, p_flags = 0, p_ip = 0;

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] trim(input logic [AW-1:0] v, input bit w);
        return w ? v : {16'h0, v[15:0]};
    endfunction

    // Expected frame and results from the requirements.
    task automatic expect_calc();
        int k = 0;
        int rp = int'(gate_sel[1:0]);
        logic [AW-1:0] sp;
        e_wide = prot_en && (gate_type == 4'hE || gate_type == 4'hF);
        e_sw   = prot_en && (cpl > gate_sel[1:0]);
        e_ringss = (rp < RINGS) ? ring_ss[rp*SELW +: SELW] : '0;
        e_seg  = e_sw ? e_ringss : cur_ss;
        sp     = e_sw ? ring_sp[rp*AW +: AW] : cur_sp;
        if (e_sw) begin
            e_data[0] = trim({16'h0, cur_ss}, e_wide);
            e_data[1] = trim(cur_sp, e_wide);
            k = 2;
        end
        e_data[k]   = trim(cur_flags, e_wide);
        e_data[k+1] = trim({16'h0, cur_cs}, e_wide);
        e_data[k+2] = trim(cur_ip, e_wide);
        e_n = k + 3;
        e_nchk = e_sw ? 2 : 1;
        for (int i = 0; i < e_n; i++) begin
            sp = sp - (e_wide ? 32'd4 : 32'd2);
            e_addr[i] = sp;
        end
        e_ss = e_seg;
        e_sp = sp;
        e_flags = (!prot_en || gate_type == 4'h6 || gate_type == 4'hE)
                  ? (cur_flags & ~32'h200) : cur_flags;
        e_cs = gate_sel;
        e_ip = e_wide ? gate_off : {cur_ip[31:16], gate_off[15:0]};
    endtask

    task automatic scramble();
        cpl = 2'($urandom);
        gate_sel = 16'($urandom);
        gate_off = $urandom;
        cur_ss = 16'($urandom);
        cur_sp = $urandom;
        cur_flags = $urandom;
        cur_cs = 16'($urandom);
        cur_ip = $urandom;
        cs_wide = 1'($urandom);
        for (int r = 0; r < RINGS; r++) begin
            ring_ss[r*SELW +: SELW] = 16'($urandom);
            ring_sp[r*AW +: AW] = $urandom;
        end
    endtask

    task automatic pick_type();
        case ($urandom_range(0, 3))
            0: gate_type = 4'h6;
            1: gate_type = 4'h7;
            2: gate_type = 4'hE;
            default: gate_type = 4'hF;
        endcase
    endtask

    // One entry: drive start, serve the ports, check pushes and outcome.
    task automatic run_one(input int err_at, input int seg_fail_at, input bit junk);
        int pidx = 0, cidx = 0, cyc = 0, exp_push;
        bit fin = 0, got_done = 0, got_abort = 0, stalled = 0, exp_abort;
        logic [AW-1:0] st_data;
        expect_calc();
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9 busy after start", {31'h0, busy}, 1);
        while (!fin && cyc < 200) begin
            cyc++;
            push_ready = 0; push_err = 0; seg_chk_ok = 1; start = 0;
            if (done || abort) begin
                got_done = done; got_abort = abort; fin = 1;
            end else begin
                if (junk && cyc == 3) begin
                    start = 1;
                    prot_en = ~prot_en;
                    scramble();
                end
                if (seg_chk_valid) begin
                    if (cidx == 0 && e_sw)
                        chk(seg_chk_sel == e_ringss, "R3 ss check sel", {16'h0, seg_chk_sel}, {16'h0, e_ringss});
                    else
                        chk(seg_chk_sel == e_cs, "R6 cs check sel", {16'h0, seg_chk_sel}, {16'h0, e_cs});
                    if (cidx == seg_fail_at) seg_chk_ok = 0;
                    cidx++;
                end
                if (push_valid) begin
                    if (stalled)
                        chk(push_data == st_data, "R10 held data", push_data, st_data);
                    if (pidx >= e_n) begin
                        chk(0, "R2 extra push", pidx, e_n);
                        push_ready = 1;
                    end else if ($urandom_range(0, 3) != 0) begin
                        chk(push_data == e_data[pidx], e_sw && pidx < 2 ? "R3 push data" : "R2 push data",
                            push_data, e_data[pidx]);
                        chk(push_addr == e_addr[pidx], "R4 push addr", push_addr, e_addr[pidx]);
                        chk(push_wide == e_wide, "R4 push width", {31'h0, push_wide}, {31'h0, e_wide});
                        chk(push_seg == e_seg, "R3 push seg", {16'h0, push_seg}, {16'h0, e_seg});
                        push_ready = 1;
                        push_err = (pidx == err_at);
                        pidx++;
                        stalled = 0;
                    end else begin
                        stalled = 1;
                        st_data = push_data;
                    end
                end
            end
            @(negedge clk);
        end
        push_ready = 0; push_err = 0; seg_chk_ok = 1; start = 0;
        exp_abort = (err_at >= 0 && err_at < e_n) || (seg_fail_at >= 0 && seg_fail_at < e_nchk);
        if (e_sw && seg_fail_at == 0) exp_push = 0;
        else if (err_at >= 0 && err_at < e_n) exp_push = err_at + 1;
        else exp_push = e_n;
        chk(fin, "R9 entry finished", {31'h0, fin}, 1);
        chk(got_abort == exp_abort, "R8 abort pulse", {31'h0, got_abort}, {31'h0, exp_abort});
        chk(got_done == !exp_abort, "R9 done pulse", {31'h0, got_done}, {31'h0, !exp_abort});
        chk(pidx == exp_push, "R8 push count", pidx, exp_push);
        chk(done == 1'b0 && abort == 1'b0, "R9 pulse one cycle", {30'h0, done, abort}, 0);
        if (!exp_abort) begin
            p_ss = e_ss; p_sp = e_sp; p_flags = e_flags; p_cs = e_cs; p_ip = e_ip;
        end
        chk(out_ss == p_ss, "R3 out_ss", {16'h0, out_ss}, {16'h0, p_ss});
        chk(out_sp == p_sp, "R4 out_sp", out_sp, p_sp);
        chk(out_flags == p_flags, "R5 out_flags", out_flags, p_flags);
        chk(out_cs == p_cs, "R6 out_cs", {16'h0, out_cs}, {16'h0, p_cs});
        chk(out_ip == p_ip, "R6 out_ip", out_ip, p_ip);
        @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog act=%0d exp=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !push_valid && !seg_chk_valid && !done && !abort, "R1 idle after reset",
            {27'h0, busy, push_valid, seg_chk_valid, done, abort}, 0);
        chk(out_sp == 0 && out_ip == 0 && out_flags == 0 && out_ss == 0 && out_cs == 0,
            "R1 outputs zero", out_ip, 0);

        // R2 protected, no switch, 32-bit interrupt gate, 16-bit CS.
        scramble(); prot_en = 1; cpl = 0; gate_sel = 16'h0010; gate_type = 4'hE;
        cs_wide = 0; cur_flags = 32'h0000_0202;
        run_one(-1, -1, 0);
        // R3 switch from ring 3 to ring 0 through a 16-bit trap gate.
        scramble(); prot_en = 1; cpl = 3; gate_sel = 16'h0008; gate_type = 4'h7;
        cs_wide = 1; cur_flags = 32'h0000_0202;
        run_one(-1, -1, 0);
        // R7 real mode with 32-bit CS and a 32-bit type code.
        scramble(); prot_en = 0; cpl = 3; gate_sel = 16'h1230; gate_type = 4'hF; cs_wide = 1;
        run_one(-1, -1, 0);
        // R8 push error in the middle of a switch frame.
        scramble(); prot_en = 1; cpl = 2; gate_sel = 16'h0021; gate_type = 4'hE;
        run_one(1, -1, 0);
        // R8 inner stack selector rejected.
        scramble(); prot_en = 1; cpl = 3; gate_sel = 16'h0002; gate_type = 4'h6;
        run_one(-1, 0, 0);
        // R8 new CS rejected after all pushes.
        scramble(); prot_en = 1; cpl = 0; gate_sel = 16'h0003; gate_type = 4'hF;
        run_one(-1, 0, 0);
        // R9 stray start with scrambled inputs during an entry.
        scramble(); prot_en = 1; cpl = 3; gate_sel = 16'h0001; gate_type = 4'h6;
        run_one(-1, -1, 1);

        for (int it = 0; it < 300; it++) begin
            int fault = $urandom_range(0, 9);
            scramble();
            prot_en = ($urandom_range(0, 3) != 0);
            pick_type();
            if (fault == 0)      run_one($urandom_range(0, 4), -1, 0);
            else if (fault == 1) run_one(-1, $urandom_range(0, 1), 0);
            else                 run_one(-1, -1, fault == 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule